// File: doc/BRIEF.md
# Condition Flags and Branch-Skip Unit

This unit keeps the processor's carry and overflow flags and decides where execution goes after a conditional branch-or-skip, a branch-and-save, or a status store or load. It tests a 16-bit accumulator and the two flags against a six-bit condition select. It produces the next instruction address and, when needed, a write to a simple synchronous memory.

The `iar` input already holds the address of the next sequential word. A skip therefore continues at `iar + 1`. A branch continues at the effective address `ea`. A branch-and-save writes `iar` into the word at `ea` and continues at `ea + 1`.

The sense of a match depends on the format:
- In the short format, a match skips one word.
- In the long format, a match stops the branch, and control falls through.

A status store reads the target word first. It then writes the word back with the flags placed in the low bits, so that the rest of the word is preserved.

Top module: `flagbranch_unit`

## Requirements
- R1: After reset, `carry`, `overflow`, `done`, `mem_re`, `mem_we` and `busy` are all 0.
- R2: The condition select `cond_sel` has one bit per condition:
  - bit 5: accumulator zero
  - bit 4: accumulator negative (bit 15 set)
  - bit 3: accumulator greater than zero (bit 15 clear and value nonzero)
  - bit 2: accumulator even (bit 0 clear)
  - bit 1: carry set
  - bit 0: overflow set

  A match means that at least one selected condition is true.
- R3: Operation code 0 is branch-or-skip. In the short format (`long_fmt`=0) it gives `next_iar` = `iar`+1 on a match and `iar` otherwise. `done` pulses for one cycle, visible after the accepting clock edge.
- R4: Long-format branch-or-skip gives `next_iar` = `iar` on a match and `ea` otherwise.
- R5: A `cond_sel` of zero never matches. Short-format branch-or-skip then falls through to `iar`, and long-format branch-or-skip branches to `ea`.
- R6: Operation code 1 in the short format is branch-and-save, and it ignores the conditions. In the cycle it reports `done`, it drives `mem_we`=1, `mem_addr`=`ea` and `mem_wdata`=`iar`, and `next_iar` = `ea`+1.
- R7: Long-format branch-and-save behaves as R6 when nothing matches. On a match it writes nothing and gives `next_iar` = `iar`.
- R8: Operation code 2 is status store. It reads the word at `ea` and then writes it back:
  - bits 15:8 are kept;
  - bits 7:2 are set to 0;
  - bit 1 takes carry;
  - bit 0 takes overflow.

  `done` and the write appear on the third edge, counting the accepting edge, and `next_iar` = `iar`.
- R9: Operation code 3 is status load. It reads the word at `ea` and sets carry from bit 1 and overflow from bit 0, ignoring all other bits. The flags and `done` update on the third edge.
- R10: When `flag_we` is high on an edge, carry takes `carry_in` and overflow takes `ovf_in`. A status load that completes on the same edge wins.
- R11: While `busy` is high, `op_valid` is ignored: no extra `done`, no write and no change to the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request, taken when not busy |
| op_code | input | 2 | 0 branch-or-skip, 1 branch-and-save, 2 status store, 3 status load |
| long_fmt | input | 1 | 1 selects the long format |
| cond_sel | input | 6 | Condition select mask |
| acc | input | 16 | Accumulator value |
| iar | input | 16 | Address of the next sequential word |
| ea | input | 16 | Effective address |
| flag_we | input | 1 | Flag update from the arithmetic unit |
| carry_in | input | 1 | New carry value |
| ovf_in | input | 1 | New overflow value |
| busy | output | 1 | A status operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| next_iar | output | 16 | Next instruction address, valid with `done` |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, one cycle after `mem_re` |
| carry | output | 1 | Carry flag |
| overflow | output | 1 | Overflow flag |

## Verification
The checker assumes two things about the memory:
- it returns read data exactly one cycle after `mem_re`;
- only status operations issue reads.

This lets it tell a status-store write from a branch-and-save write by looking back two cycles for a read. The bench models memory with that latency. It holds `mem_rdata` stable by construction and drives requests only at falling edges. It pulses `flag_we` only outside status operations, except where R10 priority is under test. This keeps the flag-from-read-data property free of interference from the arithmetic unit.

// File: rtl/flagbranch_unit.sv
`timescale 1ns/1ps
module flagbranch_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [1:0]   op_code,
  input  logic         long_fmt,
  input  logic [5:0]   cond_sel,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] iar,
  input  logic [W-1:0] ea,
  input  logic         flag_we,
  input  logic         carry_in,
  input  logic         ovf_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] next_iar,
  output logic         mem_re,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic         carry,
  output logic         overflow
);
  localparam logic [1:0] OP_BSK = 2'd0;
  localparam logic [1:0] OP_BSV = 2'd1;
  localparam logic [1:0] OP_STS = 2'd2;
  localparam logic [1:0] OP_LDS = 2'd3;
  localparam logic [W-1:0] ONE = W'(1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CAP} st_t;
  st_t st;
  logic         is_store;
  logic [W-1:0] iar_hold;

  logic acc_zero, acc_neg;
  logic [5:0] cond_now;
  logic hit, bsv_take;

  assign acc_zero = (acc == '0);
  assign acc_neg  = acc[W-1];
  assign cond_now = {acc_zero, acc_neg, !acc_neg && !acc_zero, !acc[0], carry, overflow};
  assign hit      = |(cond_now & cond_sel);
  assign bsv_take = !long_fmt || !hit;
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      is_store  <= 1'b0;
      iar_hold  <= '0;
      done      <= 1'b0;
      next_iar  <= '0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      carry     <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      if (flag_we) begin
        carry    <= carry_in;
        overflow <= ovf_in;
      end
      case (st)
        S_IDLE: if (op_valid) begin
          case (op_code)
            OP_BSK: begin
              done <= 1'b1;
              if (long_fmt) next_iar <= hit ? iar : ea;
              else          next_iar <= hit ? iar + ONE : iar;
            end
            OP_BSV: begin
              done <= 1'b1;
              if (bsv_take) begin
                mem_we    <= 1'b1;
                mem_addr  <= ea;
                mem_wdata <= iar;
                next_iar  <= ea + ONE;
              end else begin
                next_iar  <= iar;
              end
            end
            default: begin
              mem_re   <= 1'b1;
              mem_addr <= ea;
              is_store <= (op_code == OP_STS);
              iar_hold <= iar;
              st       <= S_WAIT;
            end
          endcase
        end
        S_WAIT: st <= S_CAP;
        S_CAP: begin
          st       <= S_IDLE;
          done     <= 1'b1;
          next_iar <= iar_hold;
          if (is_store) begin
            mem_we    <= 1'b1;
            mem_wdata <= {mem_rdata[W-1:8], 6'b0, carry, overflow};
          end else begin
            carry    <= mem_rdata[1];
            overflow <= mem_rdata[0];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^{OP_LDS, 1'b0};
endmodule

// File: rtl/flagbranch_unit_chk.sv
`timescale 1ns/1ps
module flagbranch_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] next_iar,
  input logic         mem_re,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic [W-1:0] mem_rdata,
  input logic         carry,
  input logic         overflow
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> !done && !mem_we && !mem_re && !carry && !overflow);

  // R11
  read_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re && !done && busy);

  // R6
  save_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_re, 2)) |-> (done && next_iar == W'(mem_addr + 1'b1)));

  // R8
  status_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_re, 2)) |->
      (mem_wdata[7:2] == 6'b0 && mem_wdata[W-1:8] == $past(mem_rdata[W-1:8]) && done));

  // R9
  status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mem_we && $past(mem_re, 2)) |->
      (carry == $past(mem_rdata[1]) && overflow == $past(mem_rdata[0])));

  // R11
  single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_re, mem_we}));
endmodule

bind flagbranch_unit flagbranch_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .next_iar(next_iar),
  .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata), .carry(carry), .overflow(overflow)
);

// File: tb/sim_flagbranch_unit.sv
`timescale 1ns/1ps
module sim_flagbranch_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, long_fmt = 1'b0, flag_we = 1'b0, carry_in = 1'b0, ovf_in = 1'b0;
  logic [1:0] op_code = 2'd0;
  logic [5:0] cond_sel = 6'd0;
  logic [15:0] acc = '0, iar = '0, ea = '0, mem_rdata = '0;
  logic busy, done, mem_re, mem_we, carry, overflow;
  logic [15:0] next_iar, mem_addr, mem_wdata;
  logic [15:0] mem [256];
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  flagbranch_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .long_fmt(long_fmt),
    .cond_sel(cond_sel), .acc(acc), .iar(iar), .ea(ea), .flag_we(flag_we),
    .carry_in(carry_in), .ovf_in(ovf_in), .busy(busy), .done(done), .next_iar(next_iar),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .carry(carry), .overflow(overflow)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  function automatic logic ref_hit(input logic [5:0] m, input logic [15:0] a, input logic c, input logic v);
    logic [5:0] k;
    k = {a == 16'd0, a[15], !a[15] && a != 16'd0, !a[0], c, v};
    return |(k & m);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic branch(input logic [1:0] code, input logic lf, input logic [5:0] m,
                        input logic [15:0] a, input logic [15:0] i, input logic [15:0] e);
    op_code = code; long_fmt = lf; cond_sel = m; acc = a; iar = i; ea = e; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic status(input logic [1:0] code, input logic [15:0] i, input logic [15:0] e);
    op_code = code; iar = i; ea = e; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_flags(input logic c, input logic v);
    flag_we = 1'b1; carry_in = c; ovf_in = v;
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 flags", {14'd0, carry, overflow}, 16'd0);
    chk("R1 mem", {13'd0, busy, mem_re, mem_we}, 16'd0);
  endtask

  task automatic t_short_skip;
    logic [15:0] accs [4] = '{16'h0000, 16'h8003, 16'h0005, 16'h0006};
    logic [5:0]  masks [5] = '{6'b100000, 6'b010000, 6'b001000, 6'b000100, 6'b110000};
    foreach (accs[x]) foreach (masks[y]) begin
      logic h;
      h = ref_hit(masks[y], accs[x], 1'b0, 1'b0);
      branch(2'd0, 1'b0, masks[y], accs[x], 16'h0120, 16'h0300);
      chk("R2 R3 short skip", next_iar, h ? 16'h0121 : 16'h0120);
      chk("R3 done pulse", {15'd0, done}, 16'd1);
    end
  endtask

  task automatic t_long_branch;
    branch(2'd0, 1'b1, 6'b001000, 16'h0042, 16'h0200, 16'h0555);
    chk("R4 long match falls through", next_iar, 16'h0200);
    branch(2'd0, 1'b1, 6'b010000, 16'h0042, 16'h0200, 16'h0555);
    chk("R4 long no match branches", next_iar, 16'h0555);
    branch(2'd0, 1'b1, 6'b000100, 16'hFFFF, 16'h0200, 16'h0777);
    chk("R2 R4 odd not even", next_iar, 16'h0777);
  endtask

  task automatic t_zero_mask;
    branch(2'd0, 1'b0, 6'b000000, 16'h0000, 16'h0010, 16'h0080);
    chk("R5 short zero mask", next_iar, 16'h0010);
    branch(2'd0, 1'b1, 6'b000000, 16'h0000, 16'h0010, 16'h0080);
    chk("R5 long zero mask", next_iar, 16'h0080);
  endtask

  task automatic t_flags;
    set_flags(1'b1, 1'b0);
    chk("R10 carry set", {14'd0, carry, overflow}, 16'b10);
    branch(2'd0, 1'b0, 6'b000010, 16'h0001, 16'h0400, 16'h0000);
    chk("R2 carry condition", next_iar, 16'h0401);
    branch(2'd0, 1'b0, 6'b000001, 16'h0001, 16'h0400, 16'h0000);
    chk("R2 overflow clear", next_iar, 16'h0400);
    set_flags(1'b0, 1'b1);
    branch(2'd0, 1'b1, 6'b000001, 16'h0001, 16'h0400, 16'h0999);
    chk("R2 R10 overflow condition", next_iar, 16'h0400);
    set_flags(1'b0, 1'b0);
  endtask

  task automatic t_save_short;
    mem[8'h30] = 16'hDEAD;
    branch(2'd1, 1'b0, 6'b100000, 16'h0000, 16'h0155, 16'h0030);
    chk("R6 short save next", next_iar, 16'h0031);
    chk("R6 write strobe", {15'd0, mem_we}, 16'd1);
    @(negedge clk);
    chk("R6 saved word", mem[8'h30], 16'h0155);
  endtask

  task automatic t_save_long;
    mem[8'h34] = 16'h1111;
    branch(2'd1, 1'b1, 6'b100000, 16'h0000, 16'h0166, 16'h0034);
    chk("R7 long save matched", next_iar, 16'h0166);
    @(negedge clk);
    chk("R7 no write on match", mem[8'h34], 16'h1111);
    branch(2'd1, 1'b1, 6'b100000, 16'h0007, 16'h0177, 16'h0034);
    chk("R7 long save taken", next_iar, 16'h0035);
    @(negedge clk);
    chk("R7 saved word", mem[8'h34], 16'h0177);
  endtask

  task automatic t_store_status;
    set_flags(1'b1, 1'b1);
    mem[8'h50] = 16'hA5FC;
    status(2'd2, 16'h0222, 16'h0050);
    chk("R8 done", {15'd0, done}, 16'd1);
    chk("R8 next", next_iar, 16'h0222);
    @(negedge clk);
    chk("R8 stored word", mem[8'h50], 16'hA503);
    set_flags(1'b0, 1'b1);
    mem[8'h51] = 16'h3CFF;
    status(2'd2, 16'h0223, 16'h0051);
    @(negedge clk);
    chk("R8 stored word v only", mem[8'h51], 16'h3C01);
    set_flags(1'b0, 1'b0);
  endtask

  task automatic t_load_status;
    mem[8'h60] = 16'hFFFE;
    status(2'd3, 16'h0300, 16'h0060);
    chk("R9 load carry only", {14'd0, carry, overflow}, 16'b10);
    chk("R9 next", next_iar, 16'h0300);
    mem[8'h61] = 16'h00FD;
    status(2'd3, 16'h0301, 16'h0061);
    chk("R9 load overflow only", {14'd0, carry, overflow}, 16'b01);
  endtask

  task automatic t_load_priority;
    mem[8'h62] = 16'h0000;
    op_code = 2'd3; ea = 16'h0062; iar = 16'h0310; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    @(negedge clk);
    flag_we = 1'b1; carry_in = 1'b1; ovf_in = 1'b1;
    @(negedge clk);
    flag_we = 1'b0;
    chk("R10 load wins", {14'd0, carry, overflow}, 16'b00);
  endtask

  task automatic t_busy;
    int dones;
    mem[8'h70] = 16'h0002;
    mem[8'h40] = 16'hBEEF;
    op_code = 2'd3; ea = 16'h0070; iar = 16'h0500; op_valid = 1'b1;
    @(negedge clk);
    op_code = 2'd1; long_fmt = 1'b0; ea = 16'h0040; iar = 16'h0600;
    dones = 0;
    @(negedge clk);
    dones += done;
    @(negedge clk);
    op_valid = 1'b0;
    dones += done;
    chk("R11 status result kept", next_iar, 16'h0500);
    chk("R11 flags from load", {14'd0, carry, overflow}, 16'b10);
    @(negedge clk);
    dones += done;
    chk("R11 one done only", 16'(dones), 16'd1);
    chk("R11 no write while busy", mem[8'h40], 16'hBEEF);
    set_flags(1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_short_skip;
    t_long_branch;
    t_zero_mask;
    t_flags;
    t_save_short;
    t_save_long;
    t_store_status;
    t_load_status;
    t_load_priority;
    t_busy;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule